// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers six interrupt request lines from a small processor's surroundings: two external inputs, three timer overflow flags and a serial flag formed as the OR of a receive flag and a transmit flag. Software masks these sources through a byte-wide enable register. A byte-wide priority register places each source in a high or a low level. Both registers are loaded through a plain write port that has a select bit. The processor core marks each instruction boundary with a one-cycle strobe. On that strobe the controller picks at most one pending source and answers with a one-cycle acknowledge that carries the source index and the 16-bit address of its service routine.

The controller keeps one in-service bit per level, which gives nested service. A high-level request may preempt a low-level routine that is running. A low-level request never preempts anything, and nothing is taken while a high-level routine runs. A return strobe from the core ends the deepest active routine. One cycle later it emits a clear pulse for that routine's flag, but only when the source is an external input, timer 0 or timer 1. The serial flags and the third timer flag are left for software to clear.

The acknowledge, the clear pulse and the write port are plain control signals. They have no valid/ready handshake and no back-pressure, because the core has to accept an acknowledge in the cycle it appears.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset no acknowledge and no clear pulse is produced, and the enable and priority registers are zero, so every request is ignored until software writes the enable register.
- R2: While enable bit 7 (global) is 0, no source is acknowledged, whatever the other enable bits hold.
- R3: A source is acknowledged only while its own enable bit is 1. The enable bits are: bit0 external 0, bit1 timer 0, bit2 external 1, bit3 timer 1, bit4 serial, bit5 timer 2. Bit 6 has no effect. A write with select 0 loads the enable register and a write with select 1 loads the priority register.
- R4: The acknowledge gives the source index (0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2) and the vector 0x0003 + 8 × index, which is 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 or 0x002B.
- R5: Among pending enabled sources of the same level, the lowest index is acknowledged first.
- R6: Priority bit n (same positions as the enable bits) set to 1 puts source n in the high level. Any pending high-level source wins over every low-level source.
- R7: While a low-level routine is in service, only high-level sources can be acknowledged. While a high-level routine is in service, nothing is acknowledged.
- R8: A return strobe ends the high-level routine if one is in service, and otherwise ends the low-level routine. If a return and a boundary strobe arrive in the same cycle, arbitration sees the in-service state from before the return.
- R9: One cycle after a return strobe that ends a routine, flag_clr pulses one-hot at the bit of that routine's source, but only for indices 0 to 3. A routine for serial or timer 2, or a return with nothing in service, gives no pulse.
- R10: The serial source is pending when ser_rx_flag or ser_tx_flag is 1.
- R11: Requests are sampled only on the clock edge where boundary is 1. The acknowledge appears on the following cycle and lasts one cycle. A request held without a boundary strobe is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects the enable register, 1 the priority register |
| reg_wr_data | input | 8 | Write data |
| ext0_req | input | 1 | External request 0 |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| ext1_req | input | 1 | External request 1 |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| tmr2_flag | input | 1 | Timer 2 flag |
| boundary | input | 1 | Instruction boundary strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| ack | output | 1 | One-cycle acknowledge |
| ack_src | output | 3 | Acknowledged source index, valid with ack |
| ack_vec | output | 16 | Service routine address, valid with ack |
| flag_clr | output | 6 | One-cycle flag clear pulse, indexed like the enable bits |

## Verification
An acknowledge is due exactly one cycle after the edge that samples boundary. A clear pulse is due one cycle after the edge that samples reti. A register write counts for a boundary strobe sampled at any later edge. The bench drives inputs on falling edges and compares every output on the following falling edge with a behavioural model that is advanced on each rising edge. Its directed checks wait one full cycle after each strobe before they sample, so each check lands on the cycle where the result is due.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int NSRC  = 6;
  localparam int IDX_W = 3;
  localparam int VEC_W = 16;
  localparam int NLVL  = 2;

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5
  } irq_src_e;

  // service routine address: fixed base plus an eight-byte slot per source
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(16'h0003) + (VEC_W'(idx) << 3);
  endfunction

  // lowest set bit of a request vector
  function automatic logic [IDX_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] pri_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) pri_q <= wr_data;
      else        en_q  <= wr_data;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int DW         = 8,
  parameter int GLOBAL_BIT = 7
) (
  input  logic [NSRC-1:0]  req,
  input  logic [DW-1:0]    en_q,
  input  logic [DW-1:0]    pri_q,
  input  logic [NLVL-1:0]  isv,
  output logic             grant,
  output logic             grant_lvl,
  output logic [IDX_W-1:0] grant_idx
);
  logic [NSRC-1:0] live, hi, lo;

  assign live = req & en_q[NSRC-1:0] & {NSRC{en_q[GLOBAL_BIT]}};
  assign hi   = live & pri_q[NSRC-1:0];
  assign lo   = live & ~pri_q[NSRC-1:0];

  always_comb begin
    grant     = 1'b0;
    grant_lvl = 1'b0;
    grant_idx = '0;
    if (!isv[1]) begin
      if (|hi) begin
        grant     = 1'b1;
        grant_lvl = 1'b1;
        grant_idx = first_set(hi);
      end else if (!isv[0] && (|lo)) begin
        grant     = 1'b1;
        grant_idx = first_set(lo);
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
`timescale 1ns/1ps
module irq_nest
  import irq_pkg::*;
#(
  parameter logic [NSRC-1:0] CLR_MASK = 6'b001111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             take_lvl,
  input  logic [IDX_W-1:0] take_idx,
  input  logic             reti,
  output logic [NLVL-1:0]  isv_q,
  output logic [NSRC-1:0]  clr_q
);
  logic [NLVL-1:0][IDX_W-1:0] src_q;
  logic [NLVL-1:0]            rel, set;
  logic [IDX_W-1:0]           rel_src;
  logic [NSRC-1:0]            clr_nxt;

  always_comb begin
    rel = '0;
    if (reti) begin
      if (isv_q[1])      rel = 2'b10;
      else if (isv_q[0]) rel = 2'b01;
    end
    rel_src = isv_q[1] ? src_q[1] : src_q[0];
    clr_nxt = (|rel) ? ((NSRC'(1) << rel_src) & CLR_MASK) : '0;
    set     = take ? (take_lvl ? 2'b10 : 2'b01) : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isv_q <= '0;
      src_q <= '0;
      clr_q <= '0;
    end else begin
      isv_q <= (isv_q & ~rel) | set;
      clr_q <= clr_nxt;
      if (take) src_q[take_lvl] <= take_idx;
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
`timescale 1ns/1ps
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int DW       = 8,
  parameter bit HAS_TMR2 = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_wr_sel,
  input  logic [DW-1:0]    reg_wr_data,
  input  logic             ext0_req,
  input  logic             tmr0_flag,
  input  logic             ext1_req,
  input  logic             tmr1_flag,
  input  logic             ser_rx_flag,
  input  logic             ser_tx_flag,
  input  logic             tmr2_flag,
  input  logic             boundary,
  input  logic             reti,
  output logic             ack,
  output logic [IDX_W-1:0] ack_src,
  output logic [VEC_W-1:0] ack_vec,
  output logic [NSRC-1:0]  flag_clr
);
  logic [DW-1:0]    en_q, pri_q;
  logic [NSRC-1:0]  req;
  logic [NLVL-1:0]  isv_q;
  logic             grant, grant_lvl, take;
  logic [IDX_W-1:0] grant_idx;
  logic             t2_req;
  logic             ack_q;
  logic [IDX_W-1:0] src_q;

  generate
    if (HAS_TMR2) begin : g_t2
      assign t2_req = tmr2_flag;
    end else begin : g_no_t2
      assign t2_req = 1'b0;
    end
  endgenerate

  assign req = {t2_req, ser_rx_flag | ser_tx_flag, tmr1_flag, ext1_req, tmr0_flag, ext0_req};

  irq_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .en_q(en_q), .pri_q(pri_q)
  );

  irq_arbiter #(.DW(DW)) arb_i (
    .req(req), .en_q(en_q), .pri_q(pri_q), .isv(isv_q),
    .grant(grant), .grant_lvl(grant_lvl), .grant_idx(grant_idx)
  );

  assign take = grant & boundary;

  irq_nest nest_i (
    .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(grant_lvl),
    .take_idx(grant_idx), .reti(reti), .isv_q(isv_q), .clr_q(flag_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      src_q <= '0;
    end else begin
      ack_q <= take;
      if (take) src_q <= grant_idx;
    end
  end

  assign ack     = ack_q;
  assign ack_src = src_q;
  assign ack_vec = vec_of(src_q);
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        reti,
  input logic        ack,
  input logic [2:0]  ack_src,
  input logic [15:0] ack_vec,
  input logic [5:0]  flag_clr,
  input logic [7:0]  en_q,
  input logic [1:0]  isv_q
);
  a_r11_ack_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(boundary));
  a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(en_q[7]));
  a_r3_source_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ((($past(en_q) >> ack_src) & 8'd1) != 8'd0));
  a_r4_vector_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ack_src <= 3'd5 && ack_vec[2:0] == 3'b011 && ack_vec[15:6] == 10'd0));
  a_r7_high_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !$past(isv_q[1]));
  a_r9_clr_after_return: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_clr) |-> $past(reti));
  a_r9_clr_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr) && flag_clr[5:4] == 2'b00);
endmodule

bind irq_ctrl_top irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .reti(reti), .ack(ack),
  .ack_src(ack_src), .ack_vec(ack_vec), .flag_clr(flag_clr),
  .en_q(en_q), .isv_q(isv_q)
);

// File: tb/irq_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
  logic [7:0]  reg_wr_data = '0;
  logic        ext0_req = 0, tmr0_flag = 0, ext1_req = 0, tmr1_flag = 0;
  logic        ser_rx_flag = 0, ser_tx_flag = 0, tmr2_flag = 0;
  logic        boundary = 0, reti = 0;
  logic        ack;
  logic [2:0]  ack_src;
  logic [15:0] ack_vec;
  logic [5:0]  flag_clr;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .ext0_req(ext0_req), .tmr0_flag(tmr0_flag),
    .ext1_req(ext1_req), .tmr1_flag(tmr1_flag), .ser_rx_flag(ser_rx_flag),
    .ser_tx_flag(ser_tx_flag), .tmr2_flag(tmr2_flag), .boundary(boundary),
    .reti(reti), .ack(ack), .ack_src(ack_src), .ack_vec(ack_vec), .flag_clr(flag_clr)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_en = 0, m_pri = 0;
  bit m_busy[2];
  int m_owner[2];
  bit e_ack = 0;
  int e_src = 0, e_clr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pri = 0; m_busy[0] = 0; m_busy[1] = 0;
      m_owner[0] = 0; m_owner[1] = 0;
      e_ack = 0; e_src = 0; e_clr = 0;
    end else begin
      bit pend[6];
      bit got;
      int who, lvl_got, done_lvl;
      pend[0] = ext0_req; pend[1] = tmr0_flag; pend[2] = ext1_req;
      pend[3] = tmr1_flag; pend[4] = ser_rx_flag || ser_tx_flag; pend[5] = tmr2_flag;
      got = 0; who = 0; lvl_got = 0;
      if (boundary && m_en[7]) begin
        for (int lv = 1; lv >= 0; lv--) begin
          bit blocked;
          blocked = m_busy[1] || (lv == 0 && m_busy[0]);
          if (!got && !blocked) begin
            for (int s = 0; s < 6; s++) begin
              if (!got && pend[s] && m_en[s] && (m_pri[s] == lv)) begin
                got = 1; who = s; lvl_got = lv;
              end
            end
          end
        end
      end
      done_lvl = -1;
      if (reti) begin
        if (m_busy[1]) done_lvl = 1;
        else if (m_busy[0]) done_lvl = 0;
      end
      e_clr = 0;
      if (done_lvl >= 0) begin
        if (m_owner[done_lvl] < 4) e_clr = 1 << m_owner[done_lvl];
        m_busy[done_lvl] = 0;
      end
      e_ack = got;
      if (got) begin
        e_src = who;
        m_busy[lvl_got] = 1;
        m_owner[lvl_got] = who;
      end
      if (reg_wr_en) begin
        if (reg_wr_sel) m_pri = reg_wr_data;
        else m_en = reg_wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11 model ack", ack, e_ack);
      if (e_ack) begin
        check("R4 model src", ack_src, e_src);
        check("R4 model vec", ack_vec, 3 + 8 * e_src);
      end
      check("R9 model clr", flag_clr, e_clr);
    end
  end

  task automatic wr(input bit sel, input int data);
    @(negedge clk); reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = 8'(data);
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic strobe(input string tag, input bit exp_ack, input int exp_src);
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
    check(tag, ack, exp_ack);
    if (exp_ack) begin
      check(tag, ack_src, exp_src);
      check(tag, ack_vec, 3 + 8 * exp_src);
    end
  endtask

  task automatic ret(input string tag, input int exp_clr);
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
    check(tag, flag_clr, exp_clr);
  endtask

  task automatic set_req(input int v);
    @(negedge clk);
    {tmr2_flag, ser_tx_flag, ser_rx_flag, tmr1_flag, ext1_req, tmr0_flag, ext0_req} = 7'(v);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset ack", ack, 0);
    check("R1 reset clr", flag_clr, 0);
    set_req(7'h7F);
    strobe("R1 masked after reset", 0, 0);
    // R2: global bit clear
    wr(0, 8'h7F);
    strobe("R2 global off", 0, 0);
    // R3: only timer 0 enabled
    wr(0, 8'h82);
    set_req(7'h03);
    strobe("R3 timer0 only", 1, 1);
    ret("R9 timer0 clear", 6'b000010);
    // R5: fixed order, all low
    wr(0, 8'hBF);
    set_req(7'h7F);
    strobe("R5 ext0 first", 1, 0);
    strobe("R7 low blocks low", 0, 0);
    ret("R8 R9 ext0 clear", 6'b000001);
    set_req(7'h7E);
    strobe("R5 timer0 next", 1, 1);
    ret("R9 timer0 clear again", 6'b000010);
    // R6: ext1 in high level
    wr(1, 8'h04);
    set_req(7'h07);
    strobe("R6 high wins", 1, 2);
    set_req(7'h03);
    strobe("R7 high busy blocks", 0, 0);
    ret("R9 ext1 clear", 6'b000100);
    strobe("R5 ext0 low", 1, 0);
    set_req(7'h07);
    strobe("R7 preempt", 1, 2);
    ret("R8 high released first", 6'b000100);
    set_req(7'h03);
    strobe("R7 low still busy", 0, 0);
    ret("R8 low released", 6'b000001);
    ret("R9 nothing in service", 0);
    // R10: serial from either flag
    wr(1, 8'h00);
    wr(0, 8'h90);
    set_req(7'h20);
    strobe("R10 tx flag", 1, 4);
    ret("R9 serial no clear", 0);
    set_req(7'h10);
    strobe("R10 rx flag", 1, 4);
    ret("R9 serial no clear rx", 0);
    // R4: timer 2 vector
    wr(0, 8'hA0);
    set_req(7'h40);
    strobe("R4 timer2 vector", 1, 5);
    ret("R9 timer2 no clear", 0);
    // R11: no strobe, no ack
    wr(0, 8'hBF);
    set_req(7'h7F);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R11 no boundary", ack, 0);
    end
    strobe("R11 strobe ack", 1, 0);
    @(negedge clk);
    check("R11 one cycle pulse", ack, 0);
    ret("R9 final clear", 6'b000001);
    set_req(0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule